// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block sequences a processor core into and out of its low-power modes. It sits between the core, the interrupt controller and the clock gating logic. Two software-visible registers hold its settings. The interrupt control register holds a stop-enable bit and a 3-bit wake priority threshold. The control register holds a 2-bit mode select. A simple register bus reaches both registers, and every access carries a supervisor/user attribute. A user-mode access is refused with a transfer error and changes nothing.

Entry into low power starts only when the core reports that a stop instruction has executed. The block decides whether entry is allowed and latches the chosen mode. It then drops the matching clock enables and raises a halted status. While halted, a path that needs no gated clock compares the interrupt requests against the threshold. When an unmasked request has a priority strictly above the threshold, the block turns the clocks back on. It waits a fixed settle count and then pulses a resume strobe to the core. A stop request that is not allowed is acknowledged at once, and the core keeps running with its clocks on.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset both registers read zero, `clk_en` is 3'b111, and `halted` and `resume` are low.
- R2: A supervisor access at address 0 reaches the interrupt control register: bit 7 is stop-enable, bits 6:4 are the wake threshold, and bits 3:0 read zero. Address 1 reaches the control register: bits 1:0 are the mode select (00 run, 01 doze, 10 wait, 11 stop), and bits 7:2 read zero. `bus_ack` is high during such an access.
- R3: A user-mode access (`bus_super` low) raises `bus_err`, leaves `bus_ack` low, and does not change any register.
- R4: Writing the registers never starts low power. Only `stop_req` does.
- R5: A `stop_req` with mode 11 and stop-enable set enters stop mode, and `clk_en` reads 3'b000 in the following cycle.
- R6: A `stop_req` with mode 11 and stop-enable clear raises `stop_ack` in the same cycle, and no clock is gated.
- R7: Doze (01) gates only the core clock, so `clk_en` is 3'b110 (bit 0 core, bit 1 platform, bit 2 peripheral). Wait (10) gates the core and platform clocks, so `clk_en` is 3'b100. Neither mode needs stop-enable.
- R8: A `stop_req` with mode 00 raises `stop_ack` in the same cycle, and the clocks stay on.
- R9: `halted` is high from the cycle after an accepted entry until the settle count ends.
- R10: Wake occurs only for a request that is set, is not masked (mask bit 1 means masked), and whose 3-bit level (source i at bits 3i+2:3i) is strictly greater than the threshold.
- R11: After wake, `clk_en` is 3'b111 with `halted` high for 4 cycles. Then `resume` is high for exactly one cycle with `halted` low, and the block returns to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_super | input | 1 | Supervisor attribute of the access |
| bus_rdata | output | 8 | Read data |
| bus_ack | output | 1 | Access accepted |
| bus_err | output | 1 | Transfer error (user access) |
| stop_req | input | 1 | Core executed a stop instruction |
| stop_ack | output | 1 | Refused or run-mode stop acknowledged |
| irq_req | input | NSRC | Pending interrupt requests |
| irq_mask | input | NSRC | Interrupt masks, 1 = masked |
| irq_lvl | input | NSRC*3 | Priority level per source |
| clk_en | output | 3 | Clock enables {peripheral, platform, core} |
| halted | output | 1 | Processor-halted status |
| resume | output | 1 | One-cycle restart strobe to the core |

## Verification
The wake comparator is driven from a vector table in which each entry puts the processor into stop mode and then applies one request pattern. The patterns are: a level just above the threshold, a level equal to it, a masked high-level source, several sources where only one is above the threshold, all sources at the threshold, and a level-0 request against a threshold of 0. Together they separate a strictly-greater comparison from greater-or-equal, and they show whether masking is honoured and whether the block picks the highest unmasked source. Directed runs through doze, wait and run-mode stop requests tell the three gating masks and the refusal path apart. User-mode writes followed by supervisor read-back show that refused accesses leave no trace.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_DOZE = 2'b01,
    MODE_WAIT = 2'b10,
    MODE_STOP = 2'b11
  } lp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_LOWP,
    ST_SETTLE,
    ST_RESUME
  } seq_st_e;

  localparam int unsigned GATE_W = 3;

  // clock enables while parked in a mode: {peripheral, platform, core}
  function automatic logic [GATE_W-1:0] mode_enables(lp_mode_e m);
    case (m)
      MODE_DOZE: return 3'b110;
      MODE_WAIT: return 3'b100;
      MODE_STOP: return 3'b000;
      default:   return 3'b111;
    endcase
  endfunction

  // entry permitted for this mode/enable pair
  function automatic logic entry_allowed(lp_mode_e m, logic stop_en);
    case (m)
      MODE_DOZE, MODE_WAIT: return 1'b1;
      MODE_STOP:            return stop_en;
      default:              return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
  parameter int unsigned LVLW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic            bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_super,
  output logic [7:0]      bus_rdata,
  output logic            bus_ack,
  output logic            bus_err,
  output logic            stop_en,
  output logic [LVLW-1:0] wake_thr,
  output logic [1:0]      mode_sel
);
  localparam int unsigned THR_LSB = 4;

  logic            en_q;
  logic [LVLW-1:0] thr_q;
  logic [1:0]      mode_q;
  logic            wr_ok;
  logic [7:0]      icr_view, lcr_view;
  logic            unused_wbits;

  assign wr_ok   = bus_sel && bus_wr && bus_super;
  assign bus_ack = bus_sel && bus_super;
  assign bus_err = bus_sel && !bus_super;
  assign unused_wbits = ^{bus_wdata[THR_LSB-1:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      thr_q  <= '0;
      mode_q <= 2'b00;
    end else if (wr_ok) begin
      if (!bus_addr) begin
        en_q  <= bus_wdata[7];
        thr_q <= bus_wdata[THR_LSB +: LVLW];
      end else begin
        mode_q <= bus_wdata[1:0];
      end
    end
  end

  always_comb begin
    icr_view = '0;
    icr_view[7] = en_q;
    icr_view[THR_LSB +: LVLW] = thr_q;
    lcr_view = {6'b0, mode_q};
    bus_rdata = bus_ack ? (bus_addr ? lcr_view : icr_view) : 8'h00;
  end

  assign stop_en  = en_q;
  assign wake_thr = thr_q;
  assign mode_sel = mode_q;

  // R3: user accesses leave register state unchanged
  a_r3_user_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_super) |=> ($stable(en_q) && $stable(thr_q) && $stable(mode_q)));
  a_r3_user_error: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_super) |-> (bus_err && !bus_ack));
endmodule

// File: rtl/lpm_wake_eval.sv
module lpm_wake_eval #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned LVLW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      irq_req,
  input  logic [NSRC-1:0]      irq_mask,
  input  logic [NSRC*LVLW-1:0] irq_lvl,
  input  logic [LVLW-1:0]      wake_thr,
  output logic                 wake,
  output logic [LVLW-1:0]      top_lvl
);
  // highest level among live, unmasked sources
  function automatic logic [LVLW-1:0] best_level(
    input logic [NSRC-1:0] req, input logic [NSRC-1:0] msk,
    input logic [NSRC*LVLW-1:0] lv);
    logic [LVLW-1:0] best;
    best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !msk[i] && (lv[i*LVLW +: LVLW] > best))
        best = lv[i*LVLW +: LVLW];
    end
    return best;
  endfunction

  assign top_lvl = best_level(irq_req, irq_mask, irq_lvl);
  assign wake    = (top_lvl > wake_thr);

  // R10: no wake without a live unmasked source, nor at top threshold
  a_r10_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ((irq_req & ~irq_mask) != '0));
  a_r10_top_thr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_thr == {LVLW{1'b1}}) |-> !wake);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic [1:0]        mode_sel,
  input  logic              stop_en,
  input  logic              wake,
  output logic              stop_ack,
  output logic [GATE_W-1:0] clk_en,
  output logic              halted,
  output logic              resume
);
  localparam int unsigned CNTW = $clog2(SETTLE_CYC + 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(SETTLE_CYC - 1);

  seq_st_e   st, st_n;
  lp_mode_e  lat_mode;
  lp_mode_e  req_mode;
  logic [CNTW-1:0] cnt;
  logic      go;

  assign req_mode = lp_mode_e'(mode_sel);
  assign go       = stop_req && entry_allowed(req_mode, stop_en);
  assign stop_ack = (st == ST_RUN) && stop_req && !go;

  always_comb begin
    st_n = st;
    case (st)
      ST_RUN:    if (go) st_n = ST_LOWP;
      ST_LOWP:   if (wake) st_n = ST_SETTLE;
      ST_SETTLE: if (cnt == CNT_LAST) st_n = ST_RESUME;
      default:   st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      lat_mode <= MODE_RUN;
      cnt      <= '0;
    end else begin
      st <= st_n;
      if (st == ST_RUN && go) lat_mode <= req_mode;
      if (st == ST_SETTLE) cnt <= cnt + 1'b1;
      else                 cnt <= '0;
    end
  end

  assign clk_en = (st == ST_LOWP) ? mode_enables(lat_mode) : {GATE_W{1'b1}};
  assign halted = (st == ST_LOWP) || (st == ST_SETTLE);
  assign resume = (st == ST_RESUME);

  // R4: without a stop request the run state is kept
  a_r4_only_stop_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !stop_req) |=> (st == ST_RUN));
  // R6: refused stop keeps clocks running
  a_r6_refused_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && stop_req && req_mode == MODE_STOP && !stop_en)
      |=> (st == ST_RUN && clk_en == {GATE_W{1'b1}}));
  // R5: stop mode gates every clock
  a_r5_stop_all_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOWP && lat_mode == MODE_STOP) |-> (clk_en == '0));
  // R10: no wake keeps the block parked
  a_r10_park_without_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOWP && !wake) |=> (st == ST_LOWP && halted));
  // R11: settle window keeps clocks on, resume follows the last settle cycle
  a_r11_settle_clocks_on: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETTLE) |-> (clk_en == {GATE_W{1'b1}} && !resume));
  a_r11_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned NSRC       = 4,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic                 bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_super,
  output logic [7:0]           bus_rdata,
  output logic                 bus_ack,
  output logic                 bus_err,
  input  logic                 stop_req,
  output logic                 stop_ack,
  input  logic [NSRC-1:0]      irq_req,
  input  logic [NSRC-1:0]      irq_mask,
  input  logic [NSRC*3-1:0]    irq_lvl,
  output logic [2:0]           clk_en,
  output logic                 halted,
  output logic                 resume
);
  localparam int unsigned LVLW = 3;

  logic            stop_en;
  logic [LVLW-1:0] wake_thr;
  logic [1:0]      mode_sel;
  logic            wake;
  logic [LVLW-1:0] top_lvl;
  logic            unused_top;

  assign unused_top = ^top_lvl;

  lpm_regs #(.LVLW(LVLW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_super(bus_super),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .stop_en(stop_en), .wake_thr(wake_thr), .mode_sel(mode_sel)
  );

  lpm_wake_eval #(.NSRC(NSRC), .LVLW(LVLW)) u_wake (
    .clk(clk), .rst_n(rst_n),
    .irq_req(irq_req), .irq_mask(irq_mask), .irq_lvl(irq_lvl),
    .wake_thr(wake_thr), .wake(wake), .top_lvl(top_lvl)
  );

  lpm_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .stop_req(stop_req), .mode_sel(mode_sel), .stop_en(stop_en),
    .wake(wake), .stop_ack(stop_ack), .clk_en(clk_en),
    .halted(halted), .resume(resume)
  );
endmodule

// File: tb/lp_wake_ctrl_test.sv
module lp_wake_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0, bus_super = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_ack, bus_err;
  logic stop_req = 0, stop_ack;
  logic [3:0] irq_req = '0, irq_mask = '0;
  logic [11:0] irq_lvl = '0;
  logic [2:0] clk_en;
  logic halted, resume;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  lp_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_super(bus_super),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .stop_req(stop_req), .stop_ack(stop_ack), .irq_req(irq_req),
    .irq_mask(irq_mask), .irq_lvl(irq_lvl), .clk_en(clk_en),
    .halted(halted), .resume(resume)
  );

  // vector: thr, req, mask, lvl, expect wake
  typedef struct packed {
    logic [2:0]  thr;
    logic [3:0]  req;
    logic [3:0]  msk;
    logic [11:0] lvl;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 4'b0001, 4'b0000, 12'o0001, 1'b1},
    '{3'd3, 4'b0001, 4'b0000, 12'o0003, 1'b0},
    '{3'd3, 4'b0001, 4'b0000, 12'o0004, 1'b1},
    '{3'd3, 4'b0010, 4'b0010, 12'o0070, 1'b0},
    '{3'd5, 4'b0011, 4'b0000, 12'o0062, 1'b1},
    '{3'd6, 4'b1111, 4'b0000, 12'o6666, 1'b0},
    '{3'd0, 4'b0001, 4'b0000, 12'o0000, 1'b0},
    '{3'd2, 4'b1000, 4'b0111, 12'o3000, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d, input logic sup);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_super = sup;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_super = 0;
    #1;
  endtask

  task automatic bus_read(input logic a, input logic sup, output logic [7:0] d,
                          output logic ack, output logic err);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_super = sup;
    #1;
    d = bus_rdata; ack = bus_ack; err = bus_err;
    @(negedge clk);
    bus_sel = 0; bus_super = 0;
    #1;
  endtask

  // issue a one-cycle stop request; returns stop_ack seen in that cycle
  task automatic pulse_stop(output logic ack);
    @(negedge clk);
    stop_req = 1;
    #1;
    ack = stop_ack;
    @(negedge clk);
    stop_req = 0;
    #1;
  endtask

  // called in the first settle cycle
  task automatic finish_wake(input string tag);
    check({tag, " R11 settle1 clk_en"}, 32'(clk_en), 32'h7);
    check({tag, " R9 settle halted"}, 32'(halted), 32'h1);
    for (int k = 0; k < 3; k++) begin
      tick();
      check({tag, " R11 settle clocks"}, 32'({clk_en, halted, resume}), 32'b1111_0);
    end
    tick();
    check({tag, " R11 resume pulse"}, 32'({resume, halted}), 32'b10);
    irq_req = '0;
    tick();
    check({tag, " R11 back to run"}, 32'({resume, halted, clk_en}), 32'b00111);
  endtask

  logic [7:0] rd;
  logic ak, er, sa;

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 clk_en", 32'(clk_en), 32'h7);
    check("R1 halted/resume", 32'({halted, resume}), 32'h0);
    bus_read(1'b0, 1'b1, rd, ak, er);
    check("R1 icr zero", 32'(rd), 32'h00);
    bus_read(1'b1, 1'b1, rd, ak, er);
    check("R1 lcr zero", 32'(rd), 32'h00);

    // R2 register map
    bus_write(1'b0, 8'hFF, 1'b1);
    bus_read(1'b0, 1'b1, rd, ak, er);
    check("R2 icr fields", 32'({rd, ak, er}), 32'({8'hF0, 2'b10}));
    bus_write(1'b1, 8'hFF, 1'b1);
    bus_read(1'b1, 1'b1, rd, ak, er);
    check("R2 lcr fields", 32'(rd), 32'h03);
    // R4 armed registers alone do not enter
    tick(); tick();
    check("R4 no entry from writes", 32'({clk_en, halted}), 32'b1110);

    // R3 user accesses
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h00; bus_super = 0;
    #1;
    check("R3 user write err/ack", 32'({bus_err, bus_ack}), 32'b10);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    bus_write(1'b1, 8'h00, 1'b0);
    bus_read(1'b0, 1'b1, rd, ak, er);
    check("R3 icr unchanged", 32'(rd), 32'hF0);
    bus_read(1'b1, 1'b1, rd, ak, er);
    check("R3 lcr unchanged", 32'(rd), 32'h03);
    bus_read(1'b0, 1'b0, rd, ak, er);
    check("R3 user read err", 32'({ak, er}), 32'b01);

    // R8 run-mode stop request
    bus_write(1'b1, 8'h00, 1'b1);
    pulse_stop(sa);
    check("R8 ack", 32'(sa), 32'h1);
    check("R8 no gating", 32'({clk_en, halted}), 32'b1110);

    // R6 stop with enable clear
    bus_write(1'b0, 8'h00, 1'b1);
    bus_write(1'b1, 8'h03, 1'b1);
    pulse_stop(sa);
    check("R6 ack", 32'(sa), 32'h1);
    check("R6 no gating", 32'({clk_en, halted}), 32'b1110);

    // R7 doze without enable
    bus_write(1'b1, 8'h01, 1'b1);
    pulse_stop(sa);
    check("R7 doze no ack", 32'(sa), 32'h0);
    check("R7 doze mask", 32'(clk_en), 32'b110);
    check("R9 doze halted", 32'(halted), 32'h1);
    irq_req = 4'b0001; irq_mask = '0; irq_lvl = 12'o0001;
    tick();
    finish_wake("doze");

    // R7 wait without enable
    bus_write(1'b1, 8'h02, 1'b1);
    pulse_stop(sa);
    check("R7 wait mask", 32'(clk_en), 32'b100);
    irq_req = 4'b0100; irq_lvl = 12'o0500;
    tick();
    finish_wake("wait");

    // R5 / R10 table in stop mode
    bus_write(1'b1, 8'h03, 1'b1);
    foreach (VECS[i]) begin
      bus_write(1'b0, {1'b1, VECS[i].thr, 4'b0}, 1'b1);
      pulse_stop(sa);
      check("R5 stop entry gates all", 32'({sa, clk_en, halted}), 32'b0_000_1);
      irq_req = VECS[i].req; irq_mask = VECS[i].msk; irq_lvl = VECS[i].lvl;
      tick();
      check($sformatf("R10 vector %0d wake", i), 32'(clk_en),
            VECS[i].exp ? 32'h7 : 32'h0);
      if (!VECS[i].exp) begin
        irq_req = 4'b0001; irq_mask = '0; irq_lvl = 12'o0007;
        tick();
      end
      finish_wake("stop");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule